// File: doc/BRIEF.md
# Four-Tributary Justifying Bit Multiplexer

The block merges four serial tributaries into a single faster serial line. Each tributary has its own clock. Every tributary bit is captured in the tributary's own clock domain into a small dual-clock elastic buffer. The buffers are drained by the aggregate clock, which runs somewhat faster than four times the tributary rate. The output is cut into fixed-length frames. A frame holds an alignment word, groups of control bits, one justification opportunity slot per tributary, and data slots. The data slots are shared among the tributaries bit by bit.

Once per frame, the block looks at how full each buffer is. A buffer at less than half depth means its tributary is running slow. For that tributary the opportunity slot then carries a dummy stuffing bit. Otherwise the slot carries the tributary's next real bit. The choice is repeated across the frame's sub-frames as a small majority-vote code, so that a receiver can remove the dummy bits.

After reset, output is held off until every buffer has filled to half depth. The first frame then starts. Sticky flags report any buffer that overran or ran dry.

Top module: `jm_top`

## Requirements
- R1: A frame is `SUBLEN*(CTRL_N+1)` bits long (192 with defaults) and is built from `CTRL_N+1` sub-frames of `SUBLEN` bits each. `frm_start` is high for exactly the one cycle in which the first bit of each frame is on `ser_dat`, so it recurs every frame length.
- R2: The first `FAW_LEN` bits of sub-frame 0 carry `FAW_PAT`, most significant bit first (default 8'hF4).
- R3: Every bit position not named in R2, R4 or R5 is a data slot. Within a frame the data slots carry tributaries 0,1,2,3,0,1,... in turn, restarting at 0 each frame. Each tributary's bits leave in the order they arrived, with none lost or repeated, as long as no flag of R8 or R9 is set.
- R4: Bit position t (0..3) of sub-frames 1 to `CTRL_N` carries tributary t's control bit. All `CTRL_N` bits of one frame are equal: 1 announces a stuffing bit and 0 announces a data bit in that frame's opportunity slot. `CTRL_N` is 3 or 5.
- R5: Tributary t's opportunity slot is bit position 4+t of the last sub-frame. It carries 0 when stuffing and the tributary's next data bit otherwise.
- R6: Each frame's decision is taken at its first bit: stuff if the buffer holds fewer than `DEPTH/2` bits, otherwise send data. Over a long run, the number of stuffed slots per frame therefore equals (data slots per tributary + 1) minus the tributary bits that arrive per frame. The first frame after reset stuffs nothing.
- R7: While reset is held, and after reset until every buffer holds `DEPTH/2` bits, `ser_dat`, `frm_start`, `ovf_flag` and `udf_flag` are 0.
- R8: `ovf_flag[t]` rises when tributary t writes into a full buffer. The flags of other tributaries are unaffected.
- R9: `udf_flag[t]` rises when the block must read from tributary t's empty buffer.
- R10: Both flag sets are sticky. Only reset clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Aggregate line clock |
| rst_n | input | 1 | Synchronous active-low reset, sampled by every clock |
| trib_clk | input | 4 | Per-tributary write clocks |
| trib_dat | input | 4 | Per-tributary serial data, one bit per rising trib_clk |
| ser_dat | output | 1 | Multiplexed serial output |
| frm_start | output | 1 | High with the first bit of each frame |
| ovf_flag | output | 4 | Sticky buffer overrun per tributary (tributary clock domain) |
| udf_flag | output | 4 | Sticky buffer underrun per tributary |

## Verification
The stuffing decision depends on a buffer fill level that cannot be seen at the ports, so it is hard to test directly. The bench runs each tributary clock at its own rate, placed so that the expected stuff fraction differs per tributary. It decodes whole frames, tallies the stuffed opportunity slots over two hundred frames, and compares each tally with the fraction computed from the clock periods. The overrun and underrun flags can only be reached by pushing a tributary's clock out of the legal band. The bench therefore speeds one tributary far up, and later stops another outright, then checks that only that tributary's flag rises and that it stays set.

// File: rtl/jm_pkg.sv
// Shared definitions for the justifying multiplexer.
// Assumes exactly four tributaries; the slot decoder uses 2-bit indices.
package jm_pkg;
    localparam int TRIB_N = 4;

    typedef enum logic [1:0] {
        SL_FAW  = 2'd0,
        SL_CTRL = 2'd1,
        SL_OPP  = 2'd2,
        SL_DATA = 2'd3
    } slot_e;
endpackage

// File: rtl/jm_fifo.sv
// Dual-clock bit FIFO with Gray-coded pointers and two-flop synchronizers.
// The write side takes one bit per write clock. The read side exposes the head
// bit and a fill count seen through the synchronized write pointer, which can
// only under-count. Assumes DEPTH is a power of two, at least 4.
module jm_fifo #(
    parameter  int DEPTH = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic        wclk,
    input  logic        wrst_n,
    input  logic        wdat,
    input  logic        rclk,
    input  logic        rrst_n,
    input  logic        rd_en,
    output logic        rdat,
    output logic [AW:0] fill,
    output logic        ovf,
    output logic        udf
);
    logic          mem [DEPTH];
    logic [AW:0]   wbin_q, wgray_q, wnext;
    logic [AW:0]   rbin_q, rgray_q, rnext;
    logic [AW:0]   rg_s1, rg_s2, wg_s1, wg_s2, wbin_s;
    logic          full, empty;

    // Write side: full when the Gray pointers differ only in the top two bits.
    assign wnext = wbin_q + 1'b1;
    assign full  = (wgray_q == {~rg_s2[AW:AW-1], rg_s2[AW-2:0]});

    // Bring the read pointer into the write domain.
    always_ff @(posedge wclk) begin
        if (!wrst_n) begin
            rg_s1 <= '0;
            rg_s2 <= '0;
        end else begin
            rg_s1 <= rgray_q;
            rg_s2 <= rg_s1;
        end
    end

    // Advance the write pointer, or latch an overrun when full.
    always_ff @(posedge wclk) begin
        if (!wrst_n) begin
            wbin_q  <= '0;
            wgray_q <= '0;
            ovf     <= 1'b0;
        end else if (full) begin
            ovf     <= 1'b1;
        end else begin
            wbin_q  <= wnext;
            wgray_q <= wnext ^ (wnext >> 1);
        end
    end

    // Store the incoming bit.
    always_ff @(posedge wclk) begin
        if (wrst_n && !full) mem[wbin_q[AW-1:0]] <= wdat;
    end

    // Bring the write pointer into the read domain.
    always_ff @(posedge rclk) begin
        if (!rrst_n) begin
            wg_s1 <= '0;
            wg_s2 <= '0;
        end else begin
            wg_s1 <= wgray_q;
            wg_s2 <= wg_s1;
        end
    end

    // Convert the synchronized Gray pointer back to binary.
    always_comb begin
        for (int i = 0; i <= AW; i++) wbin_s[i] = ^(wg_s2 >> i);
    end

    assign fill  = wbin_s - rbin_q;
    assign empty = (fill == '0);
    assign rnext = rbin_q + 1'b1;
    assign rdat  = mem[rbin_q[AW-1:0]];

    // Advance the read pointer, or latch an underrun when empty.
    always_ff @(posedge rclk) begin
        if (!rrst_n) begin
            rbin_q  <= '0;
            rgray_q <= '0;
            udf     <= 1'b0;
        end else if (rd_en) begin
            if (empty) begin
                udf <= 1'b1;
            end else begin
                rbin_q  <= rnext;
                rgray_q <= rnext ^ (rnext >> 1);
            end
        end
    end
endmodule

// File: rtl/jm_frame.sv
// Frame position counter and slot classifier.
// Counts bit positions inside sub-frames and sub-frames inside the frame,
// and names each position as alignment, control, opportunity or data.
// Also keeps the round-robin tributary pointer for data slots.
// Assumes SUBLEN >= 8 and FAW_LEN <= SUBLEN; counting advances only while run.
module jm_frame
    import jm_pkg::*;
#(
    parameter  int SUBLEN  = 48,
    parameter  int CTRL_N  = 3,
    parameter  int FAW_LEN = 8,
    localparam int BW      = $clog2(SUBLEN),
    localparam int SW      = $clog2(CTRL_N + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    output slot_e         kind,
    output logic [1:0]    trib,
    output logic [BW-1:0] bit_idx,
    output logic          first
);
    localparam logic [BW-1:0] BIT_LAST = BW'(SUBLEN - 1);
    localparam logic [BW-1:0] FAW_END  = BW'(FAW_LEN);
    localparam logic [BW-1:0] CTL_END  = BW'(4);
    localparam logic [BW-1:0] OPP_END  = BW'(8);
    localparam logic [SW-1:0] SUB_LAST = SW'(CTRL_N);

    logic [BW-1:0] bit_q;
    logic [SW-1:0] sub_q;
    logic [1:0]    rr_q;
    logic          frame_end;

    assign frame_end = (bit_q == BIT_LAST) && (sub_q == SUB_LAST);
    assign bit_idx   = bit_q;
    assign first     = (bit_q == '0) && (sub_q == '0);

    // Classify the current position.
    always_comb begin
        kind = SL_DATA;
        trib = rr_q;
        if (sub_q == '0 && bit_q < FAW_END) begin
            kind = SL_FAW;
        end else if (sub_q != '0 && bit_q < CTL_END) begin
            kind = SL_CTRL;
            trib = bit_q[1:0];
        end else if (sub_q == SUB_LAST && bit_q < OPP_END) begin
            kind = SL_OPP;
            trib = bit_q[1:0];
        end
    end

    // Step the bit, sub-frame and round-robin counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q <= '0;
            sub_q <= '0;
            rr_q  <= '0;
        end else if (run) begin
            if (bit_q == BIT_LAST) begin
                bit_q <= '0;
                sub_q <= (sub_q == SUB_LAST) ? '0 : sub_q + 1'b1;
            end else begin
                bit_q <= bit_q + 1'b1;
            end
            if (frame_end)            rr_q <= '0;
            else if (kind == SL_DATA) rr_q <= rr_q + 1'b1;
        end
    end
endmodule

// File: rtl/jm_top.sv
// Four-tributary positive-justification multiplexer.
// One elastic buffer per tributary. A frame sequencer and one per-tributary
// stuff decision, taken at the first bit of each frame, build the output.
// Assumes each tributary delivers between the per-frame data slot count and
// that count plus one bits per frame. CTRL_N is 3 or 5.
module jm_top
    import jm_pkg::*;
#(
    parameter int                 SUBLEN  = 48,
    parameter int                 CTRL_N  = 3,
    parameter int                 FAW_LEN = 8,
    parameter logic [FAW_LEN-1:0] FAW_PAT = 8'hF4,
    parameter int                 DEPTH   = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] trib_clk,
    input  logic [3:0] trib_dat,
    output logic       ser_dat,
    output logic       frm_start,
    output logic [3:0] ovf_flag,
    output logic [3:0] udf_flag
);
    localparam int          AW   = $clog2(DEPTH);
    localparam int          BW   = $clog2(SUBLEN);
    localparam logic [AW:0] HALF = (AW + 1)'(DEPTH / 2);

    slot_e               slot_kind;
    logic [1:0]          slot_trib;
    logic [BW-1:0]       slot_bit;
    logic                slot_first;
    logic                run_q;
    logic                nxt_bit;
    logic [TRIB_N-1:0]   rd_en, rdat, primed, stuff_q;
    logic [AW:0]         fill [TRIB_N];

    jm_frame #(
        .SUBLEN (SUBLEN),
        .CTRL_N (CTRL_N),
        .FAW_LEN(FAW_LEN)
    ) u_frame (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run_q),
        .kind   (slot_kind),
        .trib   (slot_trib),
        .bit_idx(slot_bit),
        .first  (slot_first)
    );

    for (genvar g = 0; g < TRIB_N; g++) begin : g_lane
        jm_fifo #(.DEPTH(DEPTH)) u_fifo (
            .wclk  (trib_clk[g]),
            .wrst_n(rst_n),
            .wdat  (trib_dat[g]),
            .rclk  (clk),
            .rrst_n(rst_n),
            .rd_en (rd_en[g]),
            .rdat  (rdat[g]),
            .fill  (fill[g]),
            .ovf   (ovf_flag[g]),
            .udf   (udf_flag[g])
        );
        assign primed[g] = (fill[g] >= HALF);
        // Read on this lane's data slots, and on its opportunity slot unless stuffing.
        assign rd_en[g]  = run_q && (slot_trib == 2'(g)) &&
                           ((slot_kind == SL_DATA) ||
                            (slot_kind == SL_OPP && !stuff_q[g]));
    end

    // Hold off the frame sequencer until every buffer is half full.
    always_ff @(posedge clk) begin
        if (!rst_n)       run_q <= 1'b0;
        else if (&primed) run_q <= 1'b1;
    end

    // Take each lane's stuff decision at the first bit of the frame.
    always_ff @(posedge clk) begin
        if (!rst_n)                   stuff_q <= '0;
        else if (run_q && slot_first) stuff_q <= ~primed;
    end

    // Select the bit for the current slot.
    always_comb begin
        case (slot_kind)
            SL_FAW:  nxt_bit = FAW_PAT[FAW_LEN - 1 - int'(slot_bit)];
            SL_CTRL: nxt_bit = stuff_q[slot_trib];
            SL_OPP:  nxt_bit = stuff_q[slot_trib] ? 1'b0 : rdat[slot_trib];
            default: nxt_bit = rdat[slot_trib];
        endcase
    end

    // Register the line output and the frame marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ser_dat   <= 1'b0;
            frm_start <= 1'b0;
        end else begin
            ser_dat   <= run_q ? nxt_bit : 1'b0;
            frm_start <= run_q && slot_first;
        end
    end
endmodule

// File: rtl/jm_chk.sv
// Property checker for jm_top, attached with bind.
// Watches the frame marker, the control bits, the stuff decisions,
// the buffer read strobes and the underrun flags in the line clock domain.
module jm_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       run,
    input logic       frm_start,
    input logic       ser_dat,
    input logic       ctl_slot,
    input logic       ctl_val,
    input logic       first,
    input logic [3:0] stuff,
    input logic [3:0] rd_en,
    input logic [3:0] udf
);
    // R1: the frame marker is a single-cycle pulse.
    assert_single_marker_R1: assert property (@(posedge clk) disable iff (!rst_n)
        frm_start |=> !frm_start);

    // R3: at most one buffer is read per line cycle.
    assert_one_reader_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_en));

    // R4: a control slot puts the lane's latched decision on the line.
    assert_ctrl_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_slot |=> (ser_dat == $past(ctl_val)));

    // R6: decisions change only at the first bit of a frame.
    assert_decision_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(run && first) |=> $stable(stuff));

    // R7: nothing leaves the block before the buffers are primed.
    assert_quiet_priming_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!frm_start && !ser_dat));

    // R10: underrun flags never fall outside reset.
    assert_udf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (udf != 4'b0) |=> ((udf & $past(udf)) == $past(udf)));
endmodule

bind jm_top jm_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_q),
    .frm_start(frm_start),
    .ser_dat  (ser_dat),
    .ctl_slot (run_q && (slot_kind == jm_pkg::SL_CTRL)),
    .ctl_val  (stuff_q[slot_trib]),
    .first    (slot_first),
    .stuff    (stuff_q),
    .rd_en    (rd_en),
    .udf      (udf_flag)
);

// File: tb/jm_top_tb_top.sv
`timescale 1ns/1ps
// Bench for jm_top. It drives four free-running tributary clocks carrying
// known bit sequences, decodes every output frame, and checks the layout,
// the control codes, the data order, the stuff rates and the flags.
module jm_top_tb_top;
    localparam int          SUBLEN  = 48;
    localparam int          CTRL_N  = 3;
    localparam int          FAW_LEN = 8;
    localparam logic [7:0]  FAW_PAT = 8'hF4;
    localparam int          FRAME   = SUBLEN * (CTRL_N + 1);
    localparam int          DPT     = (FRAME - FAW_LEN - 4 * CTRL_N - 4) / 4;
    localparam real         TCLK    = 5.0;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] trib_clk;
    logic [3:0] trib_dat;
    logic       ser_dat, frm_start;
    logic [3:0] ovf_flag, udf_flag;

    real half_p [4];
    bit  stop_c [4];
    int  checks = 0, errors = 0;

    // Receiver state
    bit  started, chk_data;
    int  pos, gap, frames, rr;
    int  ones [4];
    int  rxk  [4];
    int  stuffs [4];

    always #2.5 clk = ~clk;

    jm_top dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .trib_clk (trib_clk),
        .trib_dat (trib_dat),
        .ser_dat  (ser_dat),
        .frm_start(frm_start),
        .ovf_flag (ovf_flag),
        .udf_flag (udf_flag)
    );

    function automatic logic fbit(int t, int k);
        int x;
        x = (k * (t + 3)) ^ (k >> 4) ^ (t * 5) ^ (k >> 1);
        return logic'(^x);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Tributary clock and data sources; a sequence restarts at reset.
    for (genvar g = 0; g < 4; g++) begin : g_src
        logic c = 1'b0;
        logic d;
        int   k;
        assign trib_clk[g] = c;
        assign trib_dat[g] = d;
        initial begin
            #(0.7 * g + 0.3);
            forever begin
                #(half_p[g]);
                if (!stop_c[g]) c = ~c;
            end
        end
        initial begin
            k = 0;
            d = fbit(g, 0);
            forever begin
                @(posedge c);
                if (!rst_n) begin
                    k = 0;
                    d = fbit(g, 0);
                end else begin
                    #0.05;
                    k++;
                    d = fbit(g, k);
                end
            end
        end
    end

    // Frame decoder, sampling away from the active edge.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                started = 0; frames = 0; pos = 0; gap = 0; rr = 0;
                for (int t = 0; t < 4; t++) begin
                    rxk[t] = 0; stuffs[t] = 0; ones[t] = 0;
                end
            end else begin
                if (frm_start) begin
                    if (started) chk(gap == FRAME, "R1 frame length", gap, FRAME);
                    started = 1; pos = 0; gap = 0; rr = 0; frames++;
                    for (int t = 0; t < 4; t++) ones[t] = 0;
                end
                if (!started) begin
                    chk(ser_dat == 1'b0, "R7 line idle while priming", int'(ser_dat), 0);
                end else begin
                    int sub, b, t;
                    sub = pos / SUBLEN;
                    b   = pos % SUBLEN;
                    if (sub == 0 && b < FAW_LEN) begin
                        chk(ser_dat == FAW_PAT[FAW_LEN - 1 - b], "R2 alignment word",
                            int'(ser_dat), int'(FAW_PAT[FAW_LEN - 1 - b]));
                    end else if (sub >= 1 && b < 4) begin
                        ones[b] += int'(ser_dat);
                    end else if (sub == CTRL_N && b < 8) begin
                        t = b - 4;
                        chk(ones[t] == 0 || ones[t] == CTRL_N, "R4 control group uniform",
                            ones[t], CTRL_N);
                        if (frames == 1) chk(ones[t] == 0, "R6 no stuff in first frame", ones[t], 0);
                        if (ones[t] == CTRL_N) begin
                            chk(ser_dat == 1'b0, "R5 stuffing bit value", int'(ser_dat), 0);
                            if (chk_data && frames > 10 && frames <= 210) stuffs[t]++;
                        end else begin
                            if (chk_data)
                                chk(ser_dat == fbit(t, rxk[t]), "R5 opportunity data bit",
                                    int'(ser_dat), int'(fbit(t, rxk[t])));
                            rxk[t]++;
                        end
                    end else begin
                        t = rr;
                        rr = (rr + 1) % 4;
                        if (chk_data)
                            chk(ser_dat == fbit(t, rxk[t]), "R3 interleaved data order",
                                int'(ser_dat), int'(fbit(t, rxk[t])));
                        rxk[t]++;
                    end
                    pos++;
                    gap++;
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    task automatic do_reset();
        @(negedge clk);
        #0.37 rst_n = 1'b0;
        repeat (40) @(negedge clk);
        chk(ser_dat == 1'b0 && frm_start == 1'b0, "R7 outputs low in reset",
            int'({ser_dat, frm_start}), 0);
        chk(ovf_flag == 4'b0 && udf_flag == 4'b0, "R10 flags cleared by reset",
            int'({ovf_flag, udf_flag}), 0);
        #0.37 rst_n = 1'b1;
    endtask

    real per [4];

    initial begin
        per[0] = 22.6; per[1] = 22.4; per[2] = 22.75; per[3] = 22.5;
        for (int t = 0; t < 4; t++) begin
            half_p[t] = per[t] / 2.0;
            stop_c[t] = 0;
        end
        chk_data = 1;

        // Phase A: legal rates, full decoding and stuff tallies.
        do_reset();
        wait (frames >= 212);
        for (int t = 0; t < 4; t++) begin
            real  e;
            int   ei;
            e  = 200.0 * (real'(DPT + 1) - real'(FRAME) * TCLK / per[t]);
            ei = int'(e);
            chk(stuffs[t] >= ei - 20 && stuffs[t] <= ei + 20, "R6 stuff rate per tributary",
                stuffs[t], ei);
        end
        @(negedge clk);
        chk(ovf_flag == 4'b0, "R8 no overrun at legal rates", int'(ovf_flag), 0);
        chk(udf_flag == 4'b0, "R9 no underrun at legal rates", int'(udf_flag), 0);

        // Phase B: tributary 2 far too fast.
        chk_data = 0;
        half_p[2] = 9.0;
        do_reset();
        wait (frames >= 30);
        @(negedge clk);
        chk(ovf_flag == 4'b0100, "R8 overrun only on fast lane", int'(ovf_flag), 4);
        chk(udf_flag == 4'b0, "R9 no underrun on overrun test", int'(udf_flag), 0);
        half_p[2] = per[2] / 2.0;
        wait (frames >= 50);
        @(negedge clk);
        chk(ovf_flag == 4'b0100, "R10 overrun flag sticky", int'(ovf_flag), 4);

        // Phase C: tributary 1 stops after the first frame.
        do_reset();
        wait (frames >= 2);
        stop_c[1] = 1;
        wait (frames >= 20);
        @(negedge clk);
        chk(udf_flag == 4'b0010, "R9 underrun only on stopped lane", int'(udf_flag), 2);
        chk(ovf_flag == 4'b0, "R8 no overrun on underrun test", int'(ovf_flag), 0);
        stop_c[1] = 0;
        wait (frames >= 26);
        @(negedge clk);
        chk(udf_flag == 4'b0010, "R10 underrun flag sticky", int'(udf_flag), 2);

        finish_run();
    end
endmodule